// File: doc/BRIEF.md
# PLL Frequency Holdover Controller

This block is the control state machine that protects an oscillator's frequency when its phase-locked loop loses lock. It watches a phase-detector report of the reference-to-feedback phase error, a cycle-slip flag and a lock-status input. When the loop falls out of lock while it was locked, the controller tri-states the charge pump. The loop filter then holds its control voltage and the oscillator keeps its last frequency, while dividers and clock outputs keep running.

The pump stays tri-stated until a valid reference edge is seen at the detector. A reference counts as present only after a timeout-based monitor, running on the system clock, has seen it return. The first valid edge releases the pump and starts a reacquire window. That window lasts a fixed number of valid reference edges (64 by default), after which the controller is back in normal tracking. A separate preset control parks the pump at mid-supply for fast centring after power-up. While the preset is on, all lock tracking is suspended. A configuration input lets an out-of-lock event trigger holdover even when the loop was not reported as locked.

Top module: `holdover_ctrl`

## Requirements
- R1: `rst` is synchronous and active high. In the cycle after reset with `cfg_preset` low, all four outputs are 0 (normal tracking). With `cfg_preset` high, only `cp_preset` is 1.
- R2: An out-of-lock event is `phase_out_win` or `cycle_slip` high at a rising clock edge. In normal tracking, if `lock_in` is high at that same edge, `hold_active` and `cp_tristate` are 1 from the next cycle.
- R3: An out-of-lock event with both `lock_in` and `cfg_hold_bypass` low is ignored: all outputs stay 0.
- R4: With `cfg_hold_bypass` at 1, an out-of-lock event alone enters holdover, whatever `lock_in` is.
- R5: `lock_in` is sampled only at the edge of the event. If it drops afterwards, holdover is not left.
- R6: Holdover persists while no valid reference edge arrives. The first valid `ref_edge` makes `reacq_active` 1 and `cp_tristate` 0 in the next cycle.
- R7: The reference is judged lost after `cfg_ref_timeout` consecutive clock cycles with no `ref_edge`. After a loss, the first returning edge only re-establishes presence and is not valid. The following edge is valid.
- R8: Reacquire ends after LOCK_CYCLES (64) valid reference edges counted while reacquiring. `reacq_active` is 0 and all outputs are 0 in the cycle after the last one.
- R9: During reacquire, an out-of-lock event that meets the R2/R4 gating returns to holdover. An event that fails the gating is ignored, and the edge count continues without restarting.
- R10: While `cfg_preset` is high, from any state, the next cycle shows only `cp_preset` at 1, and out-of-lock events are ignored. Clearing it gives normal tracking (all outputs 0) in the next cycle.
- R11: At most one of `cp_preset`, `hold_active` and `reacq_active` is 1. `cp_tristate` equals `hold_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_edge | input | 1 | One-cycle pulse per reference edge seen at the phase detector |
| phase_out_win | input | 1 | Phase error outside the lock window |
| cycle_slip | input | 1 | Cycle slip flagged by the detector |
| lock_in | input | 1 | Loop lock status |
| cfg_hold_bypass | input | 1 | 1: out-of-lock alone triggers holdover |
| cfg_preset | input | 1 | 1: force charge pump to mid-supply |
| cfg_ref_timeout | input | TO_W | Clock cycles without an edge before the reference is lost |
| cp_tristate | output | 1 | Charge pump output tri-stated |
| cp_preset | output | 1 | Charge pump preset to mid-supply |
| hold_active | output | 1 | Holdover in progress |
| reacq_active | output | 1 | Reacquire window in progress |

## Verification
Every output is decoded from the registered state, so a wrong state shows at the ports in the cycle right after the edge that caused it. A gating fault shows as a spurious or missing `hold_active` one cycle after an event. A faulty reference monitor shows as a release one edge too early or too late after a timeout. A faulty reacquire counter moves the fall of `reacq_active` away from the cycle after the 64th valid edge. A misplaced preset priority lets `hold_active` appear while `cp_preset` is requested.

// File: rtl/ho_pkg.sv
package ho_pkg;

    localparam int unsigned HO_LOCK_CYCLES = 64;

    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_HOLD   = 2'd1,
        ST_REACQ  = 2'd2,
        ST_PRESET = 2'd3
    } ho_state_e;

    typedef struct packed {
        logic present;
        logic valid_edge;
    } ho_ref_s;

    typedef struct packed {
        logic cp_tristate;
        logic cp_preset;
        logic hold;
        logic reacq;
    } ho_out_s;

    function automatic ho_out_s ho_decode(input ho_state_e st);
        ho_out_s o;
        o = '0;
        case (st)
            ST_HOLD:   begin o.cp_tristate = 1'b1; o.hold = 1'b1; end
            ST_REACQ:  o.reacq = 1'b1;
            ST_PRESET: o.cp_preset = 1'b1;
            default:   o = '0;
        endcase
        return o;
    endfunction

    function automatic ho_state_e ho_reset_state(input logic preset);
        return preset ? ST_PRESET : ST_NORMAL;
    endfunction

endpackage

// File: rtl/ho_ref_monitor.sv
module ho_ref_monitor
    import ho_pkg::*;
#(
    parameter int unsigned TO_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ref_edge,
    input  logic [TO_W-1:0] cfg_timeout,
    output ho_ref_s         ref_st
);
    localparam int unsigned EW = TO_W + 1;

    logic [TO_W-1:0] gap_cnt;
    logic            present;
    logic [EW-1:0]   gap_next;

    assign gap_next = {1'b0, gap_cnt} + EW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt <= '0;
            present <= 1'b0;
        end else if (ref_edge) begin
            gap_cnt <= '0;
            present <= 1'b1;
        end else begin
            if (gap_cnt < cfg_timeout) begin
                gap_cnt <= gap_cnt + TO_W'(1);
            end
            if (gap_next >= {1'b0, cfg_timeout}) begin
                present <= 1'b0;
            end
        end
    end

    assign ref_st.present    = present;
    assign ref_st.valid_edge = ref_edge & present;
endmodule

// File: rtl/ho_lock_gate.sv
module ho_lock_gate (
    input  logic phase_out_win,
    input  logic cycle_slip,
    input  logic lock_in,
    input  logic bypass,
    output logic trigger
);
    logic oolock_ev;
    logic gate_ok;

    assign oolock_ev = phase_out_win | cycle_slip;
    assign gate_ok   = lock_in | bypass;
    assign trigger   = oolock_ev & gate_ok;
endmodule

// File: rtl/ho_reacq_counter.sv
module ho_reacq_counter #(
    parameter int unsigned LOCK_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic done
);
    localparam int unsigned CW = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign done = inc & (cnt == LAST);
endmodule

// File: rtl/ho_fsm.sv
module ho_fsm
    import ho_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cfg_preset,
    input  logic      trigger,
    input  logic      valid_edge,
    input  logic      reacq_done,
    output ho_state_e state
);
    ho_state_e nxt;

    always_comb begin
        nxt = state;
        if (cfg_preset) begin
            nxt = ST_PRESET;
        end else begin
            case (state)
                ST_PRESET: nxt = ST_NORMAL;
                ST_NORMAL: if (trigger) nxt = ST_HOLD;
                ST_HOLD:   if (valid_edge) nxt = ST_REACQ;
                ST_REACQ: begin
                    if (trigger)         nxt = ST_HOLD;
                    else if (reacq_done) nxt = ST_NORMAL;
                end
                default:   nxt = ST_NORMAL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ho_reset_state(cfg_preset);
        else     state <= nxt;
    end
endmodule

// File: rtl/holdover_ctrl.sv
module holdover_ctrl
    import ho_pkg::*;
#(
    parameter int unsigned TO_W        = 16,
    parameter int unsigned LOCK_CYCLES = HO_LOCK_CYCLES
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ref_edge,
    input  logic            phase_out_win,
    input  logic            cycle_slip,
    input  logic            lock_in,
    input  logic            cfg_hold_bypass,
    input  logic            cfg_preset,
    input  logic [TO_W-1:0] cfg_ref_timeout,
    output logic            cp_tristate,
    output logic            cp_preset,
    output logic            hold_active,
    output logic            reacq_active
);
    ho_ref_s   ref_st;
    ho_state_e state;
    ho_out_s   outs;
    logic      trigger;
    logic      reacq_done;
    logic      in_reacq;

    ho_ref_monitor #(.TO_W(TO_W)) u_refmon (
        .clk         (clk),
        .rst         (rst),
        .ref_edge    (ref_edge),
        .cfg_timeout (cfg_ref_timeout),
        .ref_st      (ref_st)
    );

    ho_lock_gate u_gate (
        .phase_out_win (phase_out_win),
        .cycle_slip    (cycle_slip),
        .lock_in       (lock_in),
        .bypass        (cfg_hold_bypass),
        .trigger       (trigger)
    );

    assign in_reacq = (state == ST_REACQ);

    ho_reacq_counter #(.LOCK_CYCLES(LOCK_CYCLES)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (!in_reacq),
        .inc  (in_reacq & ref_st.valid_edge),
        .done (reacq_done)
    );

    ho_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cfg_preset (cfg_preset),
        .trigger    (trigger),
        .valid_edge (ref_st.valid_edge),
        .reacq_done (reacq_done),
        .state      (state)
    );

    assign outs         = ho_decode(state);
    assign cp_tristate  = outs.cp_tristate;
    assign cp_preset    = outs.cp_preset;
    assign hold_active  = outs.hold;
    assign reacq_active = outs.reacq;
endmodule

// File: rtl/ho_checker.sv
module ho_checker (
    input logic clk,
    input logic rst,
    input logic ref_edge,
    input logic phase_out_win,
    input logic cycle_slip,
    input logic lock_in,
    input logic cfg_hold_bypass,
    input logic cfg_preset,
    input logic cp_tristate,
    input logic cp_preset,
    input logic hold_active,
    input logic reacq_active
);
    AST_HOLD_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_active) |-> ($past(phase_out_win || cycle_slip)
            && $past(lock_in || cfg_hold_bypass) && !$past(cfg_preset))); // R2

    AST_ONE_MODE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cp_preset, cp_tristate, reacq_active})); // R11

    AST_PRESET_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_preset) |-> (cp_preset && !hold_active)); // R10

    AST_RELEASE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_active) |-> ($past(ref_edge) || cp_preset)); // R6

    AST_REACQ_EXIT: assert property (@(posedge clk) disable iff (rst)
        ($fell(reacq_active) && !hold_active && !cp_preset) |-> $past(ref_edge)); // R8

    AST_PRESET_EXIT: assert property (@(posedge clk) disable iff (rst)
        $fell(cp_preset) |-> (!hold_active && !reacq_active)); // R10
endmodule

bind holdover_ctrl ho_checker u_chk (
    .clk             (clk),
    .rst             (rst),
    .ref_edge        (ref_edge),
    .phase_out_win   (phase_out_win),
    .cycle_slip      (cycle_slip),
    .lock_in         (lock_in),
    .cfg_hold_bypass (cfg_hold_bypass),
    .cfg_preset      (cfg_preset),
    .cp_tristate     (cp_tristate),
    .cp_preset       (cp_preset),
    .hold_active     (hold_active),
    .reacq_active    (reacq_active)
);

// File: tb/test_holdover_ctrl.sv
`timescale 1ns/1ps
module test_holdover_ctrl;
    localparam int TO_W = 16;
    localparam int NCYC = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_edge = 1'b0;
    logic phase_out_win = 1'b0;
    logic cycle_slip = 1'b0;
    logic lock_in = 1'b0;
    logic cfg_hold_bypass = 1'b0;
    logic cfg_preset = 1'b0;
    logic [TO_W-1:0] cfg_ref_timeout = 16'd12;
    logic cp_tristate, cp_preset, hold_active, reacq_active;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    holdover_ctrl #(.TO_W(TO_W), .LOCK_CYCLES(NCYC)) i_holdover_ctrl (
        .clk(clk), .rst(rst), .ref_edge(ref_edge),
        .phase_out_win(phase_out_win), .cycle_slip(cycle_slip),
        .lock_in(lock_in), .cfg_hold_bypass(cfg_hold_bypass),
        .cfg_preset(cfg_preset), .cfg_ref_timeout(cfg_ref_timeout),
        .cp_tristate(cp_tristate), .cp_preset(cp_preset),
        .hold_active(hold_active), .reacq_active(reacq_active)
    );

    task automatic expect_outs(input logic t, input logic p, input logic h,
                               input logic r, input string req);
        n_checks++;
        if ({cp_tristate, cp_preset, hold_active, reacq_active} !== {t, p, h, r}) begin
            n_fail++;
            $display("FAIL %s: tri/pre/hold/reacq actual %b%b%b%b expected %b%b%b%b",
                     req, cp_tristate, cp_preset, hold_active, reacq_active, t, p, h, r);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin
            ref_edge = 1'b1;
            @(negedge clk);
            ref_edge = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic oolock(input logic slip, input logic lk);
        if (slip) cycle_slip = 1'b1; else phase_out_win = 1'b1;
        lock_in = lk;
        @(negedge clk);
        cycle_slip = 1'b0;
        phase_out_win = 1'b0;
        lock_in = 1'b0;
    endtask

    task automatic do_reset(input logic pre);
        cfg_preset = pre;
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(1);
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        expect_outs(0, 0, 0, 0, "R1 reset normal");
        do_reset(1'b1);
        expect_outs(0, 1, 0, 0, "R1 reset preset");
        cfg_preset = 1'b0;
        idle(1);
        expect_outs(0, 0, 0, 0, "R10 preset cleared");
    endtask

    task automatic t_gate_no_lock;
        edges(4);
        oolock(1'b0, 1'b0);
        expect_outs(0, 0, 0, 0, "R3 event without lock");
        oolock(1'b1, 1'b0);
        idle(2);
        expect_outs(0, 0, 0, 0, "R3 slip without lock");
    endtask

    task automatic t_lock_enter;
        edges(3);
        oolock(1'b1, 1'b1);
        expect_outs(1, 0, 1, 0, "R2 hold on slip with lock");
        idle(3);
        expect_outs(1, 0, 1, 0, "R5 lock drop keeps hold");
        edges(1);
        expect_outs(0, 0, 0, 1, "R6 release on first valid edge");
        edges(NCYC - 1);
        expect_outs(0, 0, 0, 1, "R8 still reacquiring at 63");
        edges(1);
        expect_outs(0, 0, 0, 0, "R8 normal after 64");
    endtask

    task automatic t_bypass;
        cfg_hold_bypass = 1'b1;
        edges(2);
        oolock(1'b0, 1'b0);
        expect_outs(1, 0, 1, 0, "R4 bypass enters hold");
        cfg_hold_bypass = 1'b0;
        edges(1);
        expect_outs(0, 0, 0, 1, "R6 release after bypass hold");
        edges(NCYC);
        expect_outs(0, 0, 0, 0, "R8 normal after bypass reacquire");
    endtask

    task automatic t_ref_loss;
        edges(2);
        oolock(1'b0, 1'b1);
        expect_outs(1, 0, 1, 0, "R2 hold on window with lock");
        idle(30);
        expect_outs(1, 0, 1, 0, "R6 hold persists without reference");
        edges(1);
        expect_outs(1, 0, 1, 0, "R7 returning edge not valid");
        edges(1);
        expect_outs(0, 0, 0, 1, "R7 second edge releases");
        edges(NCYC);
        expect_outs(0, 0, 0, 0, "R8 normal after loss recovery");
    endtask

    task automatic t_reacq_retrigger;
        edges(2);
        oolock(1'b1, 1'b1);
        edges(1);
        edges(10);
        expect_outs(0, 0, 0, 1, "R9 reacquiring before retrigger");
        oolock(1'b0, 1'b1);
        expect_outs(1, 0, 1, 0, "R9 gated event returns to hold");
        edges(1);
        edges(10);
        oolock(1'b0, 1'b0);
        expect_outs(0, 0, 0, 1, "R9 ungated event ignored");
        edges(NCYC - 11);
        expect_outs(0, 0, 0, 1, "R9 count continues at 63");
        edges(1);
        expect_outs(0, 0, 0, 0, "R9 count not restarted");
    endtask

    task automatic t_preset;
        cfg_preset = 1'b1;
        idle(1);
        expect_outs(0, 1, 0, 0, "R10 preset from normal");
        oolock(1'b1, 1'b1);
        idle(1);
        expect_outs(0, 1, 0, 0, "R10 event ignored in preset");
        cfg_preset = 1'b0;
        idle(1);
        expect_outs(0, 0, 0, 0, "R10 exit preset to normal");
        edges(2);
        oolock(1'b0, 1'b1);
        expect_outs(1, 0, 1, 0, "R2 hold before preset");
        cfg_preset = 1'b1;
        idle(1);
        expect_outs(0, 1, 0, 0, "R10 preset overrides hold");
        cfg_preset = 1'b0;
        idle(1);
        expect_outs(0, 0, 0, 0, "R11 clean normal after preset");
    endtask

    initial begin
        idle(1);
        t_reset();
        t_gate_no_lock();
        t_lock_enter();
        t_bypass();
        t_ref_loss();
        t_reacq_retrigger();
        t_preset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule